// File: doc/BRIEF.md
# Supply-Loss Access Guard

This controller sits between a memory array's control strobes and the array itself. It watches two digitized supply indications: whether the supply is above the power-fail threshold, and whether it is above the lower switchover threshold. From these and the chip-enable, write-enable and output-enable strobes it produces an internal select gate, an output-drive gate and a battery-select signal. All strobes and gates are active high.

When the supply falls, an access that is under way may finish. The block then blocks every access, so the outputs float and inputs are ignored. If the access has not ended within a protect window, the block is blocked anyway. Once the supply drops below the switchover threshold, battery select is raised. Battery select stays low until the supply has been seen good at least once since reset, which keeps a newly shipped cell isolated. When the supply returns, a separate hold-off window passes before access is allowed again. Both windows are counted in clock cycles and set by the parameters `PROTECT_WAIT` (default 8) and `RESUME_WAIT` (default 12).

Top module: `supply_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `selGate`, `outGate` and `battSel` are all 0. After reset the block is in the blocked state.
- R2: In normal operation, `selGate` equals `chipEn`. `outGate` equals `chipEn & outEn & ~writeEn`.
- R3: If `supplyOk` is sampled 0 in normal operation while no access is live, both gates are 0 from the next cycle on, whatever the strobes do.
- R4: An access is live when `chipEn & (writeEn | outEn)`. If `supplyOk` is sampled 0 while an access is live, the gates keep following the strobes as in R2. This lasts until a clock edge samples the access as not live. From the next cycle on, the gates are 0.
- R5: A live access held past a supply drop keeps `selGate` high for at most `PROTECT_WAIT` cycles after the cycle in which the drop was sampled.
- R6: While blocked and armed, a cycle sampling `supplyAboveSwitch` = 0 raises `battSel` on the next cycle, with both gates 0. A cycle sampling it as 1 lowers `battSel` on the next cycle.
- R7: `battSel` stays 0 after reset until `supplyOk` has been sampled 1 at least once.
- R8: When a blocked block samples `supplyOk` = 1, the gates stay 0 for the next `RESUME_WAIT` cycles. Normal operation (R2) starts in the cycle after that.
- R9: If `supplyOk` is sampled 0 during the hold-off, the block returns to blocked. The full hold-off starts again on the next recovery.
- R10: In normal operation, an asserted `writeEn` forces `outGate` to 0 even when `chipEn` and `outEn` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| supplyOk | input | 1 | Supply above the power-fail threshold |
| supplyAboveSwitch | input | 1 | Supply above the battery switchover threshold |
| chipEn | input | 1 | Chip enable strobe (active high) |
| writeEn | input | 1 | Write enable strobe (active high) |
| outEn | input | 1 | Output enable strobe (active high) |
| selGate | output | 1 | Internal chip-select gate to the array |
| outGate | output | 1 | Output-drive gate to the data pins |
| battSel | output | 1 | Selects the internal battery as the supply |

## Verification
A supply drop is applied three ways: with the bus idle, during a read that ends on its own, and during a write held far past the protect window. These separate the immediate block, the drain of a finished access and the forced timeout. Recovery is run to completion, and is also cut short by a second drop, to tell a restarted hold-off from one that resumes. Low switchover is applied both before the supply was ever good and after, to show the battery stays isolated until armed. In normal operation, all eight strobe combinations are swept to check the gating and the write override of the output gate.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL  = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_PROTECT = 3'd2,
    ST_BATTERY = 3'd3,
    ST_RECOVER = 3'd4
  } guardState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic allowAccess;  // array may be selected
    logic battOn;       // battery drives the array
    logic cntClear;     // hold the window counter at zero
    logic cntStep;      // advance the window counter
  } guardStrobe_t;

endpackage

// File: rtl/supply_guard_path.sv
module supply_guard_path
  import supply_guard_pkg::*;
#(
  parameter int PROTECT_WAIT = 8,
  parameter int RESUME_WAIT  = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  guardStrobe_t strobe,
  input  logic         chipEn,
  input  logic         writeEn,
  input  logic         outEn,
  output logic         accessLive,
  output logic         wptDone,
  output logic         cerDone,
  output logic         selGate,
  output logic         outGate,
  output logic         battSel
);

  localparam int CNT_MAX = (PROTECT_WAIT > RESUME_WAIT) ? PROTECT_WAIT : RESUME_WAIT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] WPT_LAST = CNT_W'(PROTECT_WAIT - 1);
  localparam logic [CNT_W-1:0] CER_LAST = CNT_W'(RESUME_WAIT - 1);

  logic [CNT_W-1:0] windowCnt;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.cntClear) begin
      windowCnt <= '0;
    end else if (strobe.cntStep && windowCnt != CNT_W'(CNT_MAX)) begin
      windowCnt <= windowCnt + 1'b1;
    end
  end

  always_comb begin
    accessLive = chipEn & (writeEn | outEn);
    wptDone    = (windowCnt == WPT_LAST);
    cerDone    = (windowCnt == CER_LAST);
    selGate    = strobe.allowAccess & chipEn;
    outGate    = selGate & outEn & ~writeEn;
    battSel    = strobe.battOn;
  end

  // Battery operation never coincides with an open select gate
  assert_batt_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.battOn |-> !selGate);

  initial begin
    assert_params_R5: assert (PROTECT_WAIT >= 1 && RESUME_WAIT >= 1);
  end

endmodule

// File: rtl/supply_guard_ctrl.sv
module supply_guard_ctrl
  import supply_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         supplyOk,
  input  logic         supplyAboveSwitch,
  input  logic         accessLive,
  input  logic         wptDone,
  input  logic         cerDone,
  output guardStrobe_t strobe
);

  guardState_t state, stateNext;
  logic        armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_PROTECT;
      armed <= 1'b0;
    end else begin
      state <= stateNext;
      armed <= armed | supplyOk;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_NORMAL: begin
        if (!supplyOk) stateNext = accessLive ? ST_DRAIN : ST_PROTECT;
      end
      ST_DRAIN: begin
        if (!accessLive || wptDone) stateNext = ST_PROTECT;
      end
      ST_PROTECT: begin
        if (armed && !supplyAboveSwitch) stateNext = ST_BATTERY;
        else if (supplyOk)               stateNext = ST_RECOVER;
      end
      ST_BATTERY: begin
        if (supplyAboveSwitch) stateNext = ST_PROTECT;
      end
      ST_RECOVER: begin
        if (!supplyOk)    stateNext = ST_PROTECT;
        else if (cerDone) stateNext = ST_NORMAL;
      end
      default: stateNext = ST_PROTECT;
    endcase
  end

  always_comb begin
    strobe.allowAccess = (state == ST_NORMAL) || (state == ST_DRAIN);
    strobe.battOn      = (state == ST_BATTERY);
    strobe.cntStep     = (state == ST_DRAIN) || (state == ST_RECOVER);
    strobe.cntClear    = !strobe.cntStep;
  end

  assert_drop_leaves_normal_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL && !supplyOk) |=> (state != ST_NORMAL));

  assert_drain_timeout_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && wptDone) |=> (state == ST_PROTECT));

  assert_batt_armed_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.battOn |-> armed);

  assert_resume_after_wait_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER && supplyOk && cerDone) |=> (state == ST_NORMAL));

  assert_recover_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER && !supplyOk) |=> (state == ST_PROTECT));

endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int PROTECT_WAIT = 8,
  parameter int RESUME_WAIT  = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic supplyAboveSwitch,
  input  logic chipEn,
  input  logic writeEn,
  input  logic outEn,
  output logic selGate,
  output logic outGate,
  output logic battSel
);

  guardStrobe_t strobe;
  logic accessLive, wptDone, cerDone;

  supply_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk),
    .supplyAboveSwitch(supplyAboveSwitch), .accessLive(accessLive),
    .wptDone(wptDone), .cerDone(cerDone), .strobe(strobe)
  );

  supply_guard_path #(.PROTECT_WAIT(PROTECT_WAIT), .RESUME_WAIT(RESUME_WAIT)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chipEn(chipEn),
    .writeEn(writeEn), .outEn(outEn), .accessLive(accessLive),
    .wptDone(wptDone), .cerDone(cerDone), .selGate(selGate),
    .outGate(outGate), .battSel(battSel)
  );

endmodule

// File: tb/tb_supply_guard.sv
`timescale 1ns/1ps
module tb_supply_guard;

  localparam int PW = 8;
  localparam int RW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0, supplyAboveSwitch = 1'b0;
  logic chipEn = 1'b0, writeEn = 1'b0, outEn = 1'b0;
  logic selGate, outGate, battSel;

  always #2.5 clk = ~clk;

  supply_guard #(.PROTECT_WAIT(PW), .RESUME_WAIT(RW)) dut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk),
    .supplyAboveSwitch(supplyAboveSwitch), .chipEn(chipEn),
    .writeEn(writeEn), .outEn(outEn), .selGate(selGate),
    .outGate(outGate), .battSel(battSel)
  );

  int checks = 0;
  int errors = 0;
  // Behavioural reference: 0 run, 1 finishing access, 2 blocked, 3 on battery, 4 waiting to resume
  int mMode = 2;
  int mWait = 0;
  bit mArmed = 0;
  bit lastSel;

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkInt(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle(string tag, bit rst, bit ce, bit we, bit oe, bit ok, bit sw);
    bit allow, expSel, expOut, expBat, live;
    @(negedge clk);
    rstN = !rst; chipEn = ce; writeEn = we; outEn = oe;
    supplyOk = ok; supplyAboveSwitch = sw;
    #1;
    allow  = (mMode == 0) || (mMode == 1);
    expSel = allow && ce;
    expOut = expSel && oe && !we;
    expBat = (mMode == 3);
    check(tag, "selGate", selGate, expSel);
    check(tag, "outGate", outGate, expOut);
    check(tag, "battSel", battSel, expBat);
    lastSel = selGate;
    @(posedge clk);
    live = ce && (we || oe);
    if (rst) begin
      mMode = 2; mWait = 0; mArmed = 0;
    end else begin
      case (mMode)
        0: if (!ok) begin mMode = live ? 1 : 2; mWait = 0; end
        1: if (!live || mWait == PW - 1) mMode = 2; else mWait++;
        2: if (mArmed && !sw) mMode = 3;
           else if (ok) begin mMode = 4; mWait = 0; end
        3: if (sw) mMode = 2;
        4: if (!ok) mMode = 2;
           else if (mWait == RW - 1) mMode = 0;
           else mWait++;
        default: mMode = 2;
      endcase
      mArmed = mArmed | ok;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int selCount;
    // R1: reset state
    for (int i = 0; i < 3; i++) cycle("R1", 1, 1, 0, 1, 0, 0);
    cycle("R1", 0, 1, 0, 1, 0, 0);
    // R7: supply never good, low switchover, battery stays isolated
    for (int i = 0; i < 5; i++) cycle("R7", 0, 0, 0, 0, 0, 0);
    // R8: first recovery with a live read held throughout
    for (int i = 0; i < RW + 3; i++) cycle("R8", 0, 1, 0, 1, 1, 1);
    // R2/R10: sweep all strobe combinations in normal operation
    for (int c = 0; c < 8; c++) begin
      bit ce = c[2], we = c[1], oe = c[0];
      cycle((we && oe) ? "R10" : "R2", 0, ce, we, oe, 1, 1);
      cycle("R2", 0, ce, we, oe, 1, 1);
    end
    // R3: drop with an idle bus, then strobes are ignored
    for (int i = 0; i < 3; i++) cycle("R3", 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) cycle("R3", 0, 1, 0, 1, 0, 1);
    for (int i = 0; i < RW + 3; i++) cycle("R8", 0, 0, 0, 0, 1, 1);
    // R4: drop during a read that ends after a few cycles
    for (int i = 0; i < 4; i++) cycle("R4", 0, 1, 0, 1, 0, 1);
    for (int i = 0; i < 3; i++) cycle("R4", 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 2; i++) cycle("R4", 0, 1, 1, 0, 0, 1);
    // R6: switchover low and back
    for (int i = 0; i < 4; i++) cycle("R6", 0, 1, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) cycle("R6", 0, 1, 0, 1, 0, 1);
    for (int i = 0; i < RW + 3; i++) cycle("R8", 0, 0, 0, 0, 1, 1);
    // R5: write held far past the protect window
    selCount = 0;
    for (int i = 0; i < PW + 6; i++) begin
      cycle("R5", 0, 1, 1, 0, 0, 1);
      if (lastSel) selCount++;
    end
    checkInt("R5", "select cycles after drop", selCount, PW + 1);
    // R9: drop in the middle of the hold-off restarts it
    for (int i = 0; i < 6; i++) cycle("R9", 0, 1, 0, 1, 1, 1);
    cycle("R9", 0, 1, 0, 1, 0, 1);
    for (int i = 0; i < RW + 3; i++) cycle("R9", 0, 1, 0, 1, 1, 1);
    // R7 again after a fresh reset
    for (int i = 0; i < 2; i++) cycle("R7", 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cycle("R7", 0, 0, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule